// File: doc/BRIEF.md
# TDM Highway Receive Slot Extractor

This block sits on the receive side of a serial time-division highway that carries 32 eight-bit slots in every 8 kHz frame at 2.048 Mbit/s. It recovers the 24 channel bytes of a rate-adapted 1.544 Mbit/s carrier and throws away the eight stuffed idle slots. The idle slots follow one of two placements, the same placement the transmit side uses. In the grouped placement they fill the tail of the frame. In the spread placement every fourth slot is idle, beginning at a selectable phase.

The frame sync pulse marks the frame origin. A programmable bit offset moves the first data bit of slot 0 away from that origin. A configuration bit chooses whether each data bit is taken on the rising edge of the highway clock or on the falling edge before it. A per-slot enable mask selects which slots are delivered. Each delivered slot appears as one byte, its channel number and a one-cycle strobe.

A frame sync arriving at an unexpected bit count realigns the frame timing. It also sets a misalignment flag, which stays set until reset.

Top module: `tdm_rx_slot_extractor`

## Requirements
- R1: Bits are assembled MSB first. A slot's byte is presented on `ch_byte` with its channel on `ch_idx`, and `ch_valid` is high for exactly one cycle, starting the cycle after the clock edge that captures the slot's eighth bit.
- R2: Take the clock edge at which `fsync` is sampled high as position 0. Bit i (0 = MSB) of slot s is captured at position `cfg_offset` + 8*s + i, modulo 256. Any offset from 0 to 255 is accepted, and a slot may wrap across the next frame sync.
- R3: With `cfg_fall_edge` = 0, data is the level of `rx_data` at the rising clock edge. With `cfg_fall_edge` = 1, data is the level of `rx_data` at the falling edge just before that rising edge.
- R4: With `cfg_spread` = 0 (grouped), slots 24 to 31 are idle and slot s carries channel s.
- R5: With `cfg_spread` = 1 (spread), a slot is idle when s mod 4 equals `cfg_idle_start`. The remaining 24 slots carry channels 0 to 23 in ascending slot order.
- R6: An idle slot never produces output, whatever its mask bit says.
- R7: Bit s of `cfg_slot_en` enables output for slot s. A disabled slot produces no output, and channel numbering is unchanged by the mask.
- R8: Before the first `fsync` after reset there is no output, and none appears until position `cfg_offset` of that first frame. The first `fsync` never sets `misalign`.
- R9: An `fsync` seen at a position other than 0 of the running count restarts the count at 0 and sets `misalign`, which stays set until reset. No output is produced until the next slot-0 start, and bytes after that are correct for the new timing.
- R10: While reset is asserted and right after it, `ch_valid` and `misalign` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync pulse, sampled on the rising edge |
| rx_data | input | 1 | Serial highway data |
| cfg_fall_edge | input | 1 | 1: take data at the falling edge, 0: at the rising edge |
| cfg_spread | input | 1 | Idle slot placement: 0 grouped at frame end, 1 every fourth slot |
| cfg_idle_start | input | 2 | First idle slot in the spread placement |
| cfg_offset | input | 8 | Bit offset of slot 0 from the frame sync |
| cfg_slot_en | input | 32 | Per-slot output enable |
| ch_byte | output | 8 | Recovered channel byte |
| ch_idx | output | 5 | Channel number, 0 to 23 |
| ch_valid | output | 1 | One-cycle strobe for ch_byte and ch_idx |
| misalign | output | 1 | Sticky misplaced frame sync flag |

## Verification
The bench targets offsets that make slot 31 straddle the next frame sync, including 255. A design that wraps the position wrongly would emit a byte built from bits of two different slots. All four spread phases are swept against a channel count computed by looping over the slots. A wrong skip formula would show up as shifted channel numbers next to correct bytes.

In each edge mode the data line carries the inverted bit during the other half of the clock. A design that samples the wrong edge would therefore return complemented bytes. Sparse masks that enable idle slots catch designs that let idle data through. An early frame sync catches a design that ignores the realignment, that lets its flag drop, or that emits a half-assembled byte across the jump.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    // Placement of the stuffed idle slots inside the highway frame
    typedef enum logic {
        PLACE_GROUPED = 1'b0,
        PLACE_SPREAD  = 1'b1
    } idle_place_e;

    // Clock edge used to take each highway data bit
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } sample_edge_e;

endpackage

// File: rtl/tdm_rx_edge_sampler.sv
module tdm_rx_edge_sampler
    import tdm_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic sel_fall,
    output logic bit_o
);

    logic fall_d, fall_q;

    always_comb begin
        fall_d = din;
        bit_o  = (sample_edge_e'(sel_fall) == EDGE_FALL) ? fall_q : din;
    end

    // Half-cycle capture: holds the level seen at the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= fall_d;
    end

endmodule

// File: rtl/tdm_rx_frame_timer.sv
module tdm_rx_frame_timer #(
    parameter int FRAME_BITS = 256,
    parameter int POS_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic [POS_W-1:0] pos,
    output logic             live,
    output logic             realign,
    output logic             locked,
    output logic             misalign
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic [POS_W-1:0] cnt;
        logic             locked;
        logic             misalign;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        pos     = fsync ? '0 : tmr_q.cnt;
        realign = fsync && tmr_q.locked && (tmr_q.cnt != '0);
        live    = tmr_q.locked || fsync;

        tmr_d          = tmr_q;
        tmr_d.cnt      = (pos == LAST_POS) ? '0 : pos + 1'b1;
        tmr_d.locked   = tmr_q.locked || fsync;
        tmr_d.misalign = tmr_q.misalign || realign;

        locked   = tmr_q.locked;
        misalign = tmr_q.misalign;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R2: the running count wraps to zero after the last frame position
    p_cnt_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.locked && !fsync && tmr_q.cnt == LAST_POS) |=> (tmr_q.cnt == '0));

    // R8: once locked, the timer stays locked until reset
    p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.locked |=> tmr_q.locked);

    // R9: a misplaced sync raises the flag, which then never drops
    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> misalign);
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> misalign);

endmodule

// File: rtl/tdm_rx_slot_map.sv
module tdm_rx_slot_map
    import tdm_rx_pkg::*;
#(
    parameter int SLOTS    = 32,
    parameter int CHANNELS = 24,
    parameter int SLOT_W   = 5,
    parameter int CH_W     = 5,
    parameter int STRIDE   = 4,
    parameter int START_W  = 2
) (
    input  logic [SLOT_W-1:0]  slot,
    input  logic               spread,
    input  logic [START_W-1:0] start,
    output logic               idle,
    output logic [CH_W-1:0]    chan
);

    logic spread_hit;
    int   skipped;

    generate
        if (STRIDE > 1 && (STRIDE & (STRIDE - 1)) == 0) begin : g_pow2
            // Power-of-two stride: the phase is just the low slot bits
            always_comb spread_hit = (slot[START_W-1:0] == start);
        end else begin : g_mod
            always_comb spread_hit = ((int'(slot) % STRIDE) == int'(start));
        end
    endgenerate

    always_comb begin
        // Idle slots strictly before this one in the spread placement
        skipped = (int'(slot) + STRIDE - 1 - int'(start)) / STRIDE;
        if (idle_place_e'(spread) == PLACE_SPREAD) begin
            idle = spread_hit;
            chan = CH_W'(int'(slot) - skipped);
        end else begin
            idle = (int'(slot) >= CHANNELS);
            chan = CH_W'(slot);
        end
    end

endmodule

// File: rtl/tdm_rx_slot_extractor.sv
module tdm_rx_slot_extractor
    import tdm_rx_pkg::*;
#(
    parameter  int SLOTS      = 32,
    parameter  int SLOT_BITS  = 8,
    parameter  int CHANNELS   = 24,
    localparam int FRAME_BITS = SLOTS * SLOT_BITS,
    localparam int POS_W      = $clog2(FRAME_BITS),
    localparam int BIT_W      = $clog2(SLOT_BITS),
    localparam int SLOT_W     = $clog2(SLOTS),
    localparam int CH_W       = $clog2(CHANNELS),
    localparam int STRIDE     = SLOTS / (SLOTS - CHANNELS),
    localparam int START_W    = (STRIDE > 1) ? $clog2(STRIDE) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fsync,
    input  logic                 rx_data,
    input  logic                 cfg_fall_edge,
    input  logic                 cfg_spread,
    input  logic [START_W-1:0]   cfg_idle_start,
    input  logic [POS_W-1:0]     cfg_offset,
    input  logic [SLOTS-1:0]     cfg_slot_en,
    output logic [SLOT_BITS-1:0] ch_byte,
    output logic [CH_W-1:0]      ch_idx,
    output logic                 ch_valid,
    output logic                 misalign
);

    typedef struct packed {
        logic [SLOT_BITS-2:0] shreg;
        logic                 armed;
        logic                 valid;
        logic [SLOT_BITS-1:0] data;
        logic [CH_W-1:0]      idx;
    } rx_state_t;

    rx_state_t st_d, st_q;

    logic                 bit_s;
    logic [POS_W-1:0]     pos;
    logic                 live, realign, locked;
    logic [POS_W-1:0]     data_pos;
    logic [SLOT_W-1:0]    slot;
    logic [BIT_W-1:0]     bidx;
    logic                 slot_idle;
    logic [CH_W-1:0]      slot_chan;
    logic                 last_bit;
    logic                 emit;
    logic [SLOT_BITS-1:0] byte_now;

    tdm_rx_edge_sampler u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (rx_data),
        .sel_fall (cfg_fall_edge),
        .bit_o    (bit_s)
    );

    tdm_rx_frame_timer #(
        .FRAME_BITS (FRAME_BITS),
        .POS_W      (POS_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .pos      (pos),
        .live     (live),
        .realign  (realign),
        .locked   (locked),
        .misalign (misalign)
    );

    tdm_rx_slot_map #(
        .SLOTS    (SLOTS),
        .CHANNELS (CHANNELS),
        .SLOT_W   (SLOT_W),
        .CH_W     (CH_W),
        .STRIDE   (STRIDE),
        .START_W  (START_W)
    ) u_map (
        .slot   (slot),
        .spread (cfg_spread),
        .start  (cfg_idle_start),
        .idle   (slot_idle),
        .chan   (slot_chan)
    );

    always_comb begin
        // Position within the data frame; wraps when slot 31 straddles sync
        data_pos = pos - cfg_offset;
        slot     = data_pos[POS_W-1:BIT_W];
        bidx     = data_pos[BIT_W-1:0];
        last_bit = (bidx == BIT_W'(SLOT_BITS - 1));
        byte_now = {st_q.shreg, bit_s};

        emit = st_q.armed && live && !realign && last_bit
            && !slot_idle && cfg_slot_en[slot];

        st_d       = st_q;
        st_d.shreg = byte_now[SLOT_BITS-2:0];
        st_d.valid = emit;
        if (realign) st_d.armed = (data_pos == '0);
        else         st_d.armed = st_q.armed || (live && data_pos == '0);
        if (emit) begin
            st_d.data = byte_now;
            st_d.idx  = slot_chan;
        end

        ch_byte  = st_q.data;
        ch_idx   = st_q.idx;
        ch_valid = st_q.valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: bytes are at least eight bits apart, so the strobe never stretches
    p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |=> !ch_valid);

    // R5: the presented channel number is always a real channel
    p_chan_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |-> (ch_idx < CH_W'(CHANNELS)));

    // R6: completing an idle slot never yields a strobe
    p_idle_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && last_bit && slot_idle) |=> !ch_valid);

    // R7: completing a masked-off slot never yields a strobe
    p_mask_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && !cfg_slot_en[slot]) |=> !ch_valid);

    // R8: no output is ever seen before the timer has locked
    p_needs_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |-> locked);

endmodule

// File: tb/tb_tdm_rx_slot_extractor.sv
module tb_tdm_rx_slot_extractor;

    localparam int CLK_PERIOD = 10;
    localparam int FB         = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic        rx_data = 1'b0;
    logic        cfg_fall = 1'b0;
    logic        cfg_spread = 1'b0;
    logic [1:0]  cfg_start = 2'd0;
    logic [7:0]  cfg_off = 8'd0;
    logic [31:0] cfg_en = '1;
    logic [7:0]  ch_byte;
    logic [4:0]  ch_idx;
    logic        ch_valid;
    logic        misalign;

    int errors = 0;
    int checks = 0;
    int q_byte [256];
    int q_idx  [256];
    int qh = 0;
    int qt = 0;
    int n_out = 0;
    int t = 0;
    int seed = 0;
    bit prev_valid = 1'b0;
    bit done = 1'b0;
    string tag = "R1";

    tdm_rx_slot_extractor dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .fsync          (fsync),
        .rx_data        (rx_data),
        .cfg_fall_edge  (cfg_fall),
        .cfg_spread     (cfg_spread),
        .cfg_idle_start (cfg_start),
        .cfg_offset     (cfg_off),
        .cfg_slot_en    (cfg_en),
        .ch_byte        (ch_byte),
        .ch_idx         (ch_idx),
        .ch_valid       (ch_valid),
        .misalign       (misalign)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Idle placement per R4 / R5
    function automatic bit is_idle(int s);
        if (cfg_spread) return (s % 4) == int'(cfg_start);
        return s >= 24;
    endfunction

    // Channel number: count of non-idle slots before s (R4, R5)
    function automatic int chan_of(int s);
        int n = 0;
        for (int k = 0; k < s; k++) if (!is_idle(k)) n++;
        return n;
    endfunction

    function automatic int pat(int fr, int s);
        return (fr * 53 + s * 29 + seed) & 255;
    endfunction

    // Monitor: outputs sampled at the falling edge, away from the capture edge
    always @(negedge clk) begin
        if (rst_n && ch_valid) begin
            n_out++;
            check(!prev_valid, "R1", "strobe longer than one cycle", 1, 0);
            if (qh == qt) begin
                check(1'b0, tag, "unexpected output on channel", int'(ch_idx), -1);
            end else begin
                check(int'(ch_idx) == q_idx[qh], tag, "channel number", int'(ch_idx), q_idx[qh]);
                check(int'(ch_byte) == q_byte[qh], tag, "channel byte", int'(ch_byte), q_byte[qh]);
                qh++;
            end
        end
        prev_valid = rst_n && ch_valid;
    end

    // One highway bit; the other half-cycle carries the inverted bit (R3)
    task automatic cycle(bit b, bit fs);
        if (!cfg_fall) begin
            @(negedge clk); #1; fsync = fs; rx_data = b;
            @(posedge clk); #1; rx_data = ~b;
        end else begin
            @(posedge clk); #1; rx_data = b;
            @(negedge clk); #1; fsync = fs; rx_data = ~b;
        end
    endtask

    // Stream per R2: bit i of slot s at offset + 8*s + i after each sync
    task automatic stream(int n);
        for (int i = 0; i < n; i++) begin
            int off = int'(cfg_off);
            bit fs = (t % FB) == 0;
            bit b = 1'b0;
            if (t >= off) begin
                int u = t - off;
                int fr = u / FB;
                int w = u % FB;
                int s = w / 8;
                int bp = w % 8;
                int v = pat(fr, s);
                b = v[7 - bp];
                if (bp == 7 && !is_idle(s) && cfg_en[s]) begin
                    q_byte[qt] = v;
                    q_idx[qt] = chan_of(s);
                    qt++;
                end
            end
            cycle(b, fs);
            t++;
        end
    endtask

    task automatic prelock(int n);
        for (int i = 0; i < n; i++) cycle(((i * 7 + 3) % 3) == 0, 1'b0);
    endtask

    task automatic drain();
        if (cfg_fall) @(posedge clk);
        @(negedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fsync = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(ch_valid == 1'b0, "R10", "ch_valid in reset", int'(ch_valid), 0);
        check(misalign == 1'b0, "R10", "misalign in reset", int'(misalign), 0);
        @(negedge clk); #1;
        rst_n = 1'b1;
        qh = 0; qt = 0; t = 0; prev_valid = 1'b0;
        #1;
        check(ch_valid == 1'b0, "R10", "ch_valid after reset", int'(ch_valid), 0);
    endtask

    task automatic run_cfg(string tg, bit spread, int start, int off, bit fall,
                           logic [31:0] en, int sd, bit early_sync);
        int n0;
        tag = tg;
        cfg_spread = spread; cfg_start = 2'(start); cfg_off = 8'(off);
        cfg_fall = fall; cfg_en = en; seed = sd;
        do_reset();
        n0 = n_out;
        prelock(21);
        check(n_out == n0, "R8", "outputs before first sync", n_out - n0, 0);
        if (!early_sync) begin
            stream(3 * FB);
            drain();
            check(qh == qt, tg, "expected bytes not delivered", qt - qh, 0);
            check(misalign == 1'b0, "R8", "flag after aligned syncs", int'(misalign), 0);
        end else begin
            stream(FB + 100);
            check(misalign == 1'b0, "R8", "flag before misplaced sync", int'(misalign), 0);
            t = 0;
            stream(8);
            check(misalign == 1'b1, "R9", "flag after misplaced sync", int'(misalign), 1);
            stream(2 * FB);
            drain();
            check(qh == qt, "R9", "bytes after realignment", qt - qh, 0);
            check(misalign == 1'b1, "R9", "flag not sticky", int'(misalign), 1);
        end
    endtask

    initial begin
        run_cfg("R2/R4", 1'b0, 0, 0,   1'b0, 32'hFFFF_FFFF, 11, 1'b0);
        run_cfg("R3",    1'b0, 0, 5,   1'b1, 32'hFFFF_FFFF, 77, 1'b0);
        run_cfg("R5",    1'b1, 0, 0,   1'b0, 32'hFFFF_FFFF, 3,  1'b0);
        run_cfg("R5/R7", 1'b1, 1, 13,  1'b1, 32'hA5F0_3C96, 41, 1'b0);
        run_cfg("R2/R5", 1'b1, 2, 200, 1'b0, 32'hFFFF_FFFF, 90, 1'b0);
        run_cfg("R2/R3", 1'b1, 3, 255, 1'b1, 32'hFFFF_FFFF, 17, 1'b0);
        run_cfg("R6/R7", 1'b0, 0, 3,   1'b0, 32'h0F0F_F0F0, 58, 1'b0);
        run_cfg("R6",    1'b1, 2, 9,   1'b0, 32'h4444_4444, 29, 1'b0);
        run_cfg("R9",    1'b0, 0, 7,   1'b0, 32'hFFFF_FFFF, 66, 1'b1);
        run_cfg("R9",    1'b1, 1, 0,   1'b1, 32'hFFFF_FFFF, 5,  1'b1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule